// File: doc/BRIEF.md
# Load Data Align and Merge Unit

This combinational unit sits at the end of the memory stage of a 32-bit load/store pipeline. It takes the aligned word that memory returned for a load, together with the two low bits of the effective address, the kind of load being executed and the value the destination register holds now. From these it forms the value to write back to the register file.

Byte and halfword loads pick one lane of the word and extend it with either sign or zero bits. Full-word loads pass the word through. The two partial-word loads, load-left and load-right, splice part of the memory word into the old register contents. Which lane a given offset names depends on the endianness select. Loads whose address is misaligned for their size raise an address-error flag, and no register write happens for them.

Address translation, caching, the memory array and pipeline control are outside the block. The lane count and byte width are parameters; the defaults give a 32-bit word.

Top module: `lda_load_unit`

## Requirements
- R1: `ld_kind_i` encodes 0 = none, 1 = signed byte, 2 = unsigned byte, 3 = signed halfword, 4 = unsigned halfword, 5 = word, 6 = load-left, 7 = load-right. For kind 0, `wb_en_o` and `addr_err_o` are low and `wb_data_o` is zero.
- R2: For byte loads, big-endian (`big_endian_i` = 1) offset k selects bits [31-8k:24-8k], and little-endian offset k selects bits [8k+7:8k].
- R3: A signed byte load copies bit 7 of the selected byte into bits [31:8]. An unsigned byte load clears bits [31:8].
- R4: For halfword loads, big-endian offset 0 selects bits [31:16] and offset 2 selects [15:0]; little-endian offset 0 selects [15:0] and offset 2 selects [31:16]. The signed kind sign-extends the halfword and the unsigned kind zero-extends it.
- R5: A halfword load at an odd offset sets `addr_err_o` and clears `wb_en_o`.
- R6: A word load at offset 0 writes the memory word unchanged. At any other offset it sets `addr_err_o` and clears `wb_en_o`.
- R7: Big-endian load-left at offset k returns the memory word shifted left by 8k bits, with the vacated low 8k bits taken from the old register value. Offset 0 yields the whole memory word.
- R8: Little-endian load-left at offset k returns the memory word shifted left by 8(3-k) bits, with the vacated low bits taken from the old register value. Offset 3 yields the whole memory word.
- R9: Big-endian load-right at offset k returns the memory word shifted right by 8(3-k) bits, with the vacated high bits taken from the old register value. Offset 3 yields the whole memory word.
- R10: Little-endian load-right at offset k returns the memory word shifted right by 8k bits, with the vacated high bits taken from the old register value. Offset 0 yields the whole memory word.
- R11: Byte, load-left and load-right kinds never set `addr_err_o` and always set `wb_en_o`, whatever the offset.
- R12: Whenever `wb_en_o` is low, `wb_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ld_kind_i | input | 3 | Load kind, encoded as in R1 |
| addr_lo_i | input | 2 | Low bits of the effective address (byte offset in the word) |
| mem_word_i | input | 32 | Aligned word read from memory |
| rd_old_i | input | 32 | Current value of the destination register |
| big_endian_i | input | 1 | 1 = big-endian lane numbering, 0 = little-endian |
| wb_data_o | output | 32 | Value to write to the destination register |
| wb_en_o | output | 1 | Register write enable |
| addr_err_o | output | 1 | Address error on load |

## Verification
Two functions can act on the same input word at once: the alignment check and the lane selection or extension. A halfword or word load at a misaligned offset, using a memory word whose selected lane has its sign bit set, provokes both. The bench judges that the flag wins: the write enable is low and the data is zero, with no trace of an extended value. The partial-word merge and the endianness mapping also meet at every offset of load-left and load-right. The bench sweeps every kind, offset and endianness with words whose byte values differ from those in the old register value, and compares each cycle against table-driven expected values.

// File: rtl/lda_pkg.sv
package lda_pkg;

   typedef enum logic [2:0] {
      LK_NONE   = 3'd0,
      LK_BYTE_S = 3'd1,
      LK_BYTE_U = 3'd2,
      LK_HALF_S = 3'd3,
      LK_HALF_U = 3'd4,
      LK_WORD   = 3'd5,
      LK_LEFT   = 3'd6,
      LK_RIGHT  = 3'd7
   } ld_kind_e;

endpackage

// File: rtl/lda_lane_extract.sv
module lda_lane_extract
   import lda_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   localparam int DATA_W = BYTE_W * LANES,
   localparam int HALF_W = 2 * BYTE_W,
   localparam int HALVES = LANES / 2,
   localparam int OFF_W  = $clog2(LANES)
) (
   input  ld_kind_e          kind_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic [DATA_W-1:0] mem_i,
   input  logic              big_i,
   output logic [DATA_W-1:0] ext_o
);

   logic [BYTE_W-1:0] byte_lane [LANES];
   logic [HALF_W-1:0] half_lane [HALVES];

   for (genvar g = 0; g < LANES; g++) begin : g_byte
      assign byte_lane[g] = mem_i[g*BYTE_W +: BYTE_W];
   end

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign half_lane[h] = mem_i[h*HALF_W +: HALF_W];
   end

   logic [OFF_W-1:0]  byte_idx;
   logic [OFF_W-2:0]  half_idx;
   logic [BYTE_W-1:0] byte_sel;
   logic [HALF_W-1:0] half_sel;

   always_comb begin
      byte_idx = big_i ? (OFF_W'(LANES - 1) - off_i) : off_i;
      half_idx = big_i ? ((OFF_W-1)'(HALVES - 1) - off_i[OFF_W-1:1])
                       : off_i[OFF_W-1:1];
      byte_sel = byte_lane[byte_idx];
      half_sel = half_lane[half_idx];
   end

   always_comb begin
      unique case (kind_i)
         LK_BYTE_S: ext_o = {{(DATA_W-BYTE_W){byte_sel[BYTE_W-1]}}, byte_sel};
         LK_BYTE_U: ext_o = {{(DATA_W-BYTE_W){1'b0}}, byte_sel};
         LK_HALF_S: ext_o = {{(DATA_W-HALF_W){half_sel[HALF_W-1]}}, half_sel};
         LK_HALF_U: ext_o = {{(DATA_W-HALF_W){1'b0}}, half_sel};
         LK_WORD:   ext_o = mem_i;
         default:   ext_o = '0;
      endcase
   end

   // Signed byte result: bits from the byte's sign bit upward are all equal.
   always_comb begin
      if (kind_i == LK_BYTE_S) begin
         p_sign_fill_r3: assert ($countones(ext_o[DATA_W-1:BYTE_W-1]) == 0 ||
                                 $countones(ext_o[DATA_W-1:BYTE_W-1]) == DATA_W-BYTE_W+1)
            else $error("signed byte result not uniformly filled");
      end
   end

endmodule

// File: rtl/lda_partial_merge.sv
module lda_partial_merge
   import lda_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   localparam int DATA_W = BYTE_W * LANES,
   localparam int OFF_W  = $clog2(LANES)
) (
   input  ld_kind_e          kind_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic [DATA_W-1:0] mem_i,
   input  logic [DATA_W-1:0] old_i,
   input  logic              big_i,
   output logic [DATA_W-1:0] merged_o
);

   logic [BYTE_W-1:0] mem_lane [LANES];
   logic [BYTE_W-1:0] old_lane [LANES];
   logic [OFF_W-1:0]  shl;
   logic [OFF_W-1:0]  shr;
   logic [DATA_W-1:0] left_w;
   logic [DATA_W-1:0] right_w;

   // Lane shift amounts: endianness mirrors the offset for each direction.
   always_comb begin
      shl = big_i ? off_i : (OFF_W'(LANES - 1) - off_i);
      shr = big_i ? (OFF_W'(LANES - 1) - off_i) : off_i;
   end

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      localparam logic [OFF_W-1:0] J = OFF_W'(j);
      assign mem_lane[j] = mem_i[j*BYTE_W +: BYTE_W];
      assign old_lane[j] = old_i[j*BYTE_W +: BYTE_W];
      assign left_w[j*BYTE_W +: BYTE_W] =
         (J >= shl) ? mem_lane[J - shl] : old_lane[j];
      assign right_w[j*BYTE_W +: BYTE_W] =
         (({1'b0, J} + {1'b0, shr}) < (OFF_W+1)'(LANES)) ? mem_lane[J + shr]
                                                         : old_lane[j];
   end

   always_comb begin
      merged_o = (kind_i == LK_RIGHT) ? right_w : left_w;
   end

   // Boundary offsets of each direction must return the memory word whole.
   always_comb begin
      if (kind_i == LK_LEFT && big_i && off_i == '0) begin
         p_left_be_whole_r7: assert (merged_o == mem_i)
            else $error("big-endian left merge at offset 0 altered the word");
      end
      if (kind_i == LK_LEFT && !big_i && off_i == OFF_W'(LANES - 1)) begin
         p_left_le_whole_r8: assert (merged_o == mem_i)
            else $error("little-endian left merge at top offset altered the word");
      end
      if (kind_i == LK_RIGHT && big_i && off_i == OFF_W'(LANES - 1)) begin
         p_right_be_whole_r9: assert (merged_o == mem_i)
            else $error("big-endian right merge at top offset altered the word");
      end
      if (kind_i == LK_RIGHT && !big_i && off_i == '0) begin
         p_right_le_whole_r10: assert (merged_o == mem_i)
            else $error("little-endian right merge at offset 0 altered the word");
      end
   end

endmodule

// File: rtl/lda_align_check.sv
module lda_align_check
   import lda_pkg::*;
#(
   parameter int LANES = 4,
   localparam int OFF_W = $clog2(LANES)
) (
   input  ld_kind_e         kind_i,
   input  logic [OFF_W-1:0] off_i,
   output logic             misaligned_o
);

   always_comb begin
      unique case (kind_i)
         LK_HALF_S, LK_HALF_U: misaligned_o = off_i[0];
         LK_WORD:              misaligned_o = (off_i != '0);
         default:              misaligned_o = 1'b0;
      endcase
   end

   always_comb begin
      if (kind_i inside {LK_BYTE_S, LK_BYTE_U, LK_LEFT, LK_RIGHT}) begin
         p_no_fault_r11: assert (!misaligned_o)
            else $error("byte or partial-word load flagged as misaligned");
      end
   end

endmodule

// File: rtl/lda_load_unit.sv
module lda_load_unit
   import lda_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   localparam int DATA_W = BYTE_W * LANES,
   localparam int OFF_W  = $clog2(LANES)
) (
   input  logic [2:0]        ld_kind_i,
   input  logic [OFF_W-1:0]  addr_lo_i,
   input  logic [DATA_W-1:0] mem_word_i,
   input  logic [DATA_W-1:0] rd_old_i,
   input  logic              big_endian_i,
   output logic [DATA_W-1:0] wb_data_o,
   output logic              wb_en_o,
   output logic              addr_err_o
);

   if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 4");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("BYTE_W must be positive");
   end

   ld_kind_e          kind;
   logic [DATA_W-1:0] ext_val;
   logic [DATA_W-1:0] merge_val;
   logic              misaligned;

   assign kind = ld_kind_e'(ld_kind_i);

   lda_lane_extract #(.BYTE_W(BYTE_W), .LANES(LANES)) extract_i (
      .kind_i (kind),
      .off_i  (addr_lo_i),
      .mem_i  (mem_word_i),
      .big_i  (big_endian_i),
      .ext_o  (ext_val)
   );

   lda_partial_merge #(.BYTE_W(BYTE_W), .LANES(LANES)) merge_i (
      .kind_i   (kind),
      .off_i    (addr_lo_i),
      .mem_i    (mem_word_i),
      .old_i    (rd_old_i),
      .big_i    (big_endian_i),
      .merged_o (merge_val)
   );

   lda_align_check #(.LANES(LANES)) align_i (
      .kind_i       (kind),
      .off_i        (addr_lo_i),
      .misaligned_o (misaligned)
   );

   always_comb begin
      addr_err_o = misaligned;
      wb_en_o    = (kind != LK_NONE) && !misaligned;
      if (!wb_en_o)
         wb_data_o = '0;
      else if (kind == LK_LEFT || kind == LK_RIGHT)
         wb_data_o = merge_val;
      else
         wb_data_o = ext_val;
   end

   always_comb begin
      if (kind == LK_NONE) begin
         p_idle_quiet_r1: assert (!wb_en_o && !addr_err_o && wb_data_o == '0)
            else $error("idle kind produced activity");
      end
      if (addr_err_o) begin
         p_fault_blocks_write_r5: assert (!wb_en_o && wb_data_o == '0)
            else $error("address error with write enabled");
      end
      if (kind == LK_WORD && addr_lo_i == '0) begin
         p_word_pass_r6: assert (wb_en_o && wb_data_o == mem_word_i)
            else $error("aligned word load did not pass the word");
      end
   end

endmodule

// File: tb/lda_load_unit_tb.sv
module lda_load_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  kind_s = 3'd0;
   logic [1:0]  off_s = 2'd0;
   logic [31:0] mem_s = 32'h0;
   logic [31:0] old_s = 32'h0;
   logic        be_s = 1'b0;
   logic [31:0] wb_data;
   logic        wb_en;
   logic        addr_err;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 8 ns period, 125 MHz

   lda_load_unit dut_i (
      .ld_kind_i    (kind_s),
      .addr_lo_i    (off_s),
      .mem_word_i   (mem_s),
      .rd_old_i     (old_s),
      .big_endian_i (be_s),
      .wb_data_o    (wb_data),
      .wb_en_o      (wb_en),
      .addr_err_o   (addr_err)
   );

   // Table-driven reference built from the requirement text.
   task automatic model(input logic [2:0] k, input logic [1:0] o,
                        input logic [31:0] m, input logic [31:0] r,
                        input logic be, output logic [31:0] d,
                        output logic en, output logic er, output string tag);
      logic [7:0]  b;
      logic [15:0] h;
      d = 32'h0; en = 1'b1; er = 1'b0; tag = "R1";
      case (k)
         3'd0: begin en = 1'b0; tag = "R1"; end
         3'd1, 3'd2: begin
            b = be ? m[8*(3-o) +: 8] : m[8*o +: 8];
            d = (k == 3'd1 && b[7]) ? {24'hFFFFFF, b} : {24'h0, b};
            tag = "R2/R3/R11";
         end
         3'd3, 3'd4: begin
            if (o[0]) begin er = 1'b1; en = 1'b0; tag = "R5/R12"; end
            else begin
               if (be) h = (o == 2'd0) ? m[31:16] : m[15:0];
               else    h = (o == 2'd0) ? m[15:0]  : m[31:16];
               d = (k == 3'd3 && h[15]) ? {16'hFFFF, h} : {16'h0, h};
               tag = "R4";
            end
         end
         3'd5: begin
            if (o != 2'd0) begin er = 1'b1; en = 1'b0; tag = "R6/R12"; end
            else begin d = m; tag = "R6"; end
         end
         3'd6: begin
            if (be) begin
               tag = "R7/R11";
               case (o)
                  2'd0: d = m;
                  2'd1: d = {m[23:0], r[7:0]};
                  2'd2: d = {m[15:0], r[15:0]};
                  default: d = {m[7:0], r[23:0]};
               endcase
            end else begin
               tag = "R8/R11";
               case (o)
                  2'd0: d = {m[7:0], r[23:0]};
                  2'd1: d = {m[15:0], r[15:0]};
                  2'd2: d = {m[23:0], r[7:0]};
                  default: d = m;
               endcase
            end
         end
         default: begin
            if (be) begin
               tag = "R9/R11";
               case (o)
                  2'd0: d = {r[31:8], m[31:24]};
                  2'd1: d = {r[31:16], m[31:16]};
                  2'd2: d = {r[31:24], m[31:8]};
                  default: d = m;
               endcase
            end else begin
               tag = "R10/R11";
               case (o)
                  2'd0: d = m;
                  2'd1: d = {r[31:24], m[31:8]};
                  2'd2: d = {r[31:16], m[31:16]};
                  default: d = {r[31:8], m[31:24]};
               endcase
            end
         end
      endcase
   endtask

   task automatic compare(input string tag, input logic [31:0] d,
                          input logic en, input logic er);
      checks++;
      if (wb_data !== d || wb_en !== en || addr_err !== er) begin
         failures++;
         $display("FAIL %s kind=%0d off=%0d be=%0b: got data=%h en=%0b err=%0b expected data=%h en=%0b err=%0b",
                  tag, kind_s, off_s, be_s, wb_data, wb_en, addr_err, d, en, er);
      end
   endtask

   // Drive just after a rising edge, judge on the following falling edge.
   task automatic apply(input logic [2:0] k, input logic [1:0] o,
                        input logic [31:0] m, input logic [31:0] r,
                        input logic be);
      logic [31:0] d;
      logic        en;
      logic        er;
      string       tag;
      @(posedge clk);
      #1;
      kind_s = k; off_s = o; mem_s = m; old_s = r; be_s = be;
      model(k, o, m, r, be, d, en, er, tag);
      @(negedge clk);
      compare(tag, d, en, er);
   endtask

   task automatic sweep(input logic [31:0] m, input logic [31:0] r);
      for (int be = 0; be < 2; be++)
         for (int k = 0; k < 8; k++)
            for (int o = 0; o < 4; o++)
               apply(3'(k), 2'(o), m, r, 1'(be));
   endtask

   initial begin
      repeat (4) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: idle state out of reset
      compare("R1", 32'h0, 1'b0, 1'b0);

      // Distinct byte values, mixed sign bits in every lane.
      sweep(32'h8192A3B4, 32'hC5D6E7F8);
      sweep(32'h7F0180FF, 32'h12345678);
      sweep(32'h00FF7F80, 32'hFFFFFFFF);
      sweep(32'hFFFFFFFF, 32'h00000000);

      // R5/R12: misaligned halfword whose lane would sign-extend.
      apply(3'd3, 2'd1, 32'hFFFF8000, 32'h11111111, 1'b1);
      apply(3'd3, 2'd3, 32'h8000FFFF, 32'h11111111, 1'b0);
      // R6/R12: misaligned word.
      apply(3'd5, 2'd2, 32'hDEADBEEF, 32'h0, 1'b1);
      // R1: back to idle after activity.
      apply(3'd0, 2'd3, 32'hDEADBEEF, 32'hCAFEF00D, 1'b1);

      for (int i = 0; i < 3000; i++)
         apply(3'($urandom), 2'($urandom), $urandom, $urandom, 1'($urandom));

      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule